// File: doc/BRIEF.md
# Ready-Count Bus Master with Timeout

This block carries out one bus transfer at a time on a simple pipelined on-chip bus. A host asks for a read or a write by pulsing `start` with a command bit, an address and (for writes) a data word. The engine then puts a single-cycle strobe on the bus, together with the address and write data. After that it watches the two-bit ready counter that the slave drives.

The transfer ends on the first poll edge at which the counter reads zero. For a read, the bus read data is latched on that same edge. If the counter stays nonzero for `LIMIT` poll edges, the engine gives up. It then reports the transfer as unacknowledged and leaves the latched read data as it was. In either case the host sees a one-cycle `done` pulse, with `timed_out` marking a transfer that was abandoned.

The address is 23 bits wide. This is two bits more than main memory needs: one bit separates memory from IO space, and one more lets memory appear mirrored so that its size can be probed at boot. Data is 32 bits wide. The atomic and non-cacheable sideband outputs are tied low.

Top module: `rdycnt_bus_master`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows both strobes low, `busy`, `done` and `timed_out` low, `bus_addr`, `bus_wdata` and `rd_data` all zero.
- R2: A rising edge with `start` high and `busy` low begins a transfer. In the next cycle exactly one strobe is high: `bus_wr` when `cmd_write`=1, `bus_rd` when `cmd_write`=0. In that cycle `bus_addr` equals `cmd_addr`, and `bus_wdata` equals `cmd_wdata` for a write or zero for a read.
- R3: A strobe is high for exactly one cycle per transfer, and `bus_rd` and `bus_wr` are never high together.
- R4: Outside the strobe cycle, `bus_addr` and `bus_wdata` are zero.
- R5: The ready counter is ignored at the edge that ends the strobe cycle. At each later edge it is polled, and the first poll edge that sees 0 completes the transfer. `done` is then high for exactly the following cycle, with `timed_out` low.
- R6: A completed read loads `bus_rdata`, as sampled on the completing edge, into `rd_data`. A write leaves `rd_data` unchanged, and `rd_data` holds its value between completions.
- R7: If the counter is nonzero on all `LIMIT` poll edges, then after the `LIMIT`-th poll edge `done` and `timed_out` are both high for one cycle, and `rd_data` is unchanged. A zero seen on the `LIMIT`-th poll edge is still a normal completion.
- R8: `busy` is high from the strobe cycle through the last poll cycle and low in the `done` cycle. A `start` seen while `busy` is high has no effect on the bus.
- R9: `bus_atomic` and `bus_nocache` are always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a transfer (taken only when idle) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W (23) | Transfer address |
| cmd_wdata | input | DATA_W (32) | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| timed_out | output | 1 | With `done`: no acknowledge within `LIMIT` polls |
| rd_data | output | DATA_W (32) | Last captured read data |
| bus_addr | output | ADDR_W (23) | Bus address, valid in strobe cycle |
| bus_wdata | output | DATA_W (32) | Bus write data, valid in write strobe cycle |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_atomic | output | 1 | Atomic sideband, held low |
| bus_nocache | output | 1 | Non-cacheable sideband, held low |
| bus_rdata | input | DATA_W (32) | Read data from slave |
| bus_rdy_cnt | input | RDY_W (2) | Slave ready countdown, 0 = complete |

## Verification
The bench builds the block with its defaults: 23-bit address, 32-bit data, a 2-bit ready counter and a limit of 50 polls. With this limit, directed latencies of 49 and 50 nonzero polls land exactly on both sides of the timeout boundary, and a latency of 60 shows that the engine abandons the transfer at the limit. Random latencies of 0 to 11 and occasional long stalls cover normal completion. Garbage read data during the stall and a zero counter during the strobe cycle test that capture and polling begin only at the right edge.

// File: rtl/rbm_pkg.sv
// Shared definitions for the ready-count bus master.
// Assumes nothing beyond IEEE 1800-2017.
package rbm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_POLL   = 2'd2
    } rbm_state_e;
endpackage

// File: rtl/rbm_timer.sv
// Poll counter: counts poll cycles and flags the last permitted one.
// Assumes LIMIT >= 2; clear has priority over step.
module rbm_timer #(
    parameter int LIMIT = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    // Purpose: advance once per poll cycle, restart outside polling.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/rbm_capture.sv
// Read-data holding register: loads on request, otherwise keeps its value.
// Assumes the load strobe is a single cycle wide.
module rbm_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    // Purpose: latch bus read data on a completing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/rbm_ctrl.sv
// Transfer sequencer: idle -> one strobe cycle -> polling until the ready
// counter is zero or the poll limit is reached. Drives the bus strobes and
// the done/timeout pulses. Assumes rdy_zero is the decoded ready counter.
module rbm_ctrl #(
    parameter int ADDR_W = 23,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              rdy_zero,
    input  logic              poll_last,
    output rbm_pkg::rbm_state_e state,
    output logic              capture,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              done,
    output logic              timed_out
);
    import rbm_pkg::*;

    logic is_read;

    // Purpose: state sequencing and registered bus/host outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            is_read   <= 1'b0;
            bus_rd    <= 1'b0;
            bus_wr    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            done      <= 1'b0;
            timed_out <= 1'b0;
        end else begin
            bus_rd    <= 1'b0;
            bus_wr    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            done      <= 1'b0;
            timed_out <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_STROBE;
                        is_read   <= !cmd_write;
                        bus_rd    <= !cmd_write;
                        bus_wr    <= cmd_write;
                        bus_addr  <= cmd_addr;
                        bus_wdata <= cmd_write ? cmd_wdata : '0;
                    end
                end
                ST_STROBE: begin
                    state <= ST_POLL;
                end
                ST_POLL: begin
                    if (rdy_zero) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else if (poll_last) begin
                        state     <= ST_IDLE;
                        done      <= 1'b1;
                        timed_out <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: request read-data capture on the completing poll edge.
    assign capture = (state == ST_POLL) && rdy_zero && is_read;
endmodule

// File: rtl/rdycnt_bus_master.sv
// Top: single-outstanding bus master polling a slave ready countdown, with
// a poll-count limit. Assumes the slave holds the counter nonzero until the
// transfer finishes; sideband outputs are held low.
module rdycnt_bus_master #(
    parameter int ADDR_W = 23,
    parameter int DATA_W = 32,
    parameter int RDY_W  = 2,
    parameter int LIMIT  = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic              timed_out,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_atomic,
    output logic              bus_nocache,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [RDY_W-1:0]  bus_rdy_cnt
);
    import rbm_pkg::*;

    rbm_state_e state;
    logic       rdy_zero;
    logic       poll_last;
    logic       capture;

    // Purpose: decode completion from the ready countdown.
    assign rdy_zero = (bus_rdy_cnt == '0);

    rbm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .rdy_zero  (rdy_zero),
        .poll_last (poll_last),
        .state     (state),
        .capture   (capture),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .done      (done),
        .timed_out (timed_out)
    );

    rbm_timer #(.LIMIT(LIMIT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state != ST_POLL),
        .step  (state == ST_POLL),
        .last  (poll_last)
    );

    rbm_capture #(.DATA_W(DATA_W)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (capture),
        .din   (bus_rdata),
        .dout  (rd_data)
    );

    // Purpose: host status and unused sideband lines.
    assign busy        = (state != ST_IDLE);
    assign bus_atomic  = 1'b0;
    assign bus_nocache = 1'b0;
endmodule

// File: rtl/rbm_checker.sv
// Protocol checker for rdycnt_bus_master, bound to every instance.
// Observes ports only; keeps its own poll-cycle count and last command kind.
module rbm_checker #(
    parameter int ADDR_W = 23,
    parameter int DATA_W = 32,
    parameter int LIMIT  = 50
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              timed_out,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_atomic,
    input logic              bus_nocache,
    input logic [DATA_W-1:0] bus_rdata
);
    logic        last_rd;
    int unsigned polls;

    // Purpose: remember the kind of the current transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_rd <= 1'b0;
        else if (bus_rd) last_rd <= 1'b1;
        else if (bus_wr) last_rd <= 1'b0;
    end

    // Purpose: count cycles spent busy after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy)        polls <= 0;
        else if (!(bus_rd || bus_wr)) polls <= polls + 1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !bus_rd && !bus_wr && !done && !busy);
    p_start_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> (bus_rd || bus_wr));
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    p_rd_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> !bus_rd);
    p_wr_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !bus_wr);
    p_idle_bus_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd || bus_wr) |-> (bus_addr == '0) && (bus_wdata == '0));
    p_done_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_read_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && !timed_out && last_rd |-> rd_data == $past(bus_rdata));
    p_write_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && !last_rd |-> $stable(rd_data));
    p_timeout_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timed_out |-> done && $stable(rd_data));
    p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        polls <= LIMIT);
    p_strobe_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> busy);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_busy_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !(bus_rd || bus_wr) |=> !(bus_rd || bus_wr));
    p_sideband_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_atomic && !bus_nocache);
endmodule

bind rdycnt_bus_master rbm_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LIMIT(LIMIT)
) u_rbm_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .timed_out   (timed_out),
    .rd_data     (rd_data),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_atomic  (bus_atomic),
    .bus_nocache (bus_nocache),
    .bus_rdata   (bus_rdata)
);

// File: tb/rdycnt_bus_master_bench.sv
// Bench: directed boundary transfers plus seeded random ones, with a
// behavioural slave driven from tasks on the falling edge.
module rdycnt_bus_master_bench;
    localparam int ADDR_W = 23;
    localparam int DATA_W = 32;
    localparam int RDY_W  = 2;
    localparam int LIMIT  = 50;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              cmd_write = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [DATA_W-1:0] cmd_wdata = '0;
    logic              busy, done, timed_out;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic              bus_rd, bus_wr, bus_atomic, bus_nocache;
    logic [DATA_W-1:0] bus_rdata = '0;
    logic [RDY_W-1:0]  bus_rdy_cnt = '1;

    int checks = 0;
    int failures = 0;
    logic [DATA_W-1:0] exp_rd = '0;

    always #2 clk = ~clk;

    rdycnt_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RDY_W(RDY_W), .LIMIT(LIMIT))
    u_rdycnt_bus_master (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .timed_out(timed_out), .rd_data(rd_data), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_atomic(bus_atomic), .bus_nocache(bus_nocache),
        .bus_rdata(bus_rdata), .bus_rdy_cnt(bus_rdy_cnt)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected outcome of a transfer, computed from R5/R7.
    function automatic bit exp_timeout(input int lat);
        return lat >= LIMIT;
    endfunction

    function automatic int exp_polls(input int lat);
        return (lat >= LIMIT) ? LIMIT : lat + 1;
    endfunction

    task automatic run_txn(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                           input int lat, input logic [DATA_W-1:0] rv, input bit poke);
        int npoll;
        npoll = exp_polls(lat);
        @(negedge clk);
        start = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = wd;
        bus_rdy_cnt = '0; bus_rdata = $urandom;
        @(negedge clk);
        chk(bus_rd == !wr && bus_wr == wr, "R2 strobe kind", {bus_rd, bus_wr}, {!wr, wr});
        chk(bus_addr == a, "R2 address", 64'(bus_addr), 64'(a));
        chk(bus_wdata == (wr ? wd : '0), "R2 wdata", 64'(bus_wdata), 64'(wr ? wd : '0));
        chk(busy, "R8 busy in strobe", busy, 1);
        start = poke;  // poke: start held during the wait must be ignored (R8)
        cmd_addr = ~a;
        bus_rdy_cnt = '0;  // seen at end of strobe cycle: ignored (R5)
        @(negedge clk);
        chk(!bus_rd && !bus_wr, "R3 strobe one cycle", {bus_rd, bus_wr}, 0);
        chk(bus_addr == '0 && bus_wdata == '0, "R4 bus zero", {bus_addr, bus_wdata}, 0);
        chk(busy && !done, "R5 zero at strobe edge ignored", {busy, done}, 2'b10);
        for (int k = 1; k <= npoll; k++) begin
            if (k <= lat) begin
                bus_rdy_cnt = RDY_W'($urandom_range(1, 3));
                bus_rdata = $urandom;
            end else begin
                bus_rdy_cnt = '0;
                bus_rdata = rv;
            end
            @(negedge clk);
            if (k < npoll)
                chk(busy && !done && !bus_rd && !bus_wr, "R8 busy while polling",
                    {busy, done, bus_rd, bus_wr}, 4'b1000);
        end
        start = 1'b0;
        if (!wr && !exp_timeout(lat)) exp_rd = rv;
        chk(done && (timed_out == exp_timeout(lat)), exp_timeout(lat) ? "R7 timeout pulse" : "R5 done pulse",
            {done, timed_out}, {1'b1, exp_timeout(lat)});
        chk(!busy, "R8 idle in done cycle", busy, 0);
        chk(rd_data == exp_rd, wr ? "R6 write keeps rd_data" : (exp_timeout(lat) ? "R7 rd_data kept" : "R6 read capture"),
            64'(rd_data), 64'(exp_rd));
        bus_rdata = $urandom; bus_rdy_cnt = '1;
        @(negedge clk);
        chk(!done && !timed_out, "R5 done one cycle", {done, timed_out}, 0);
        chk(rd_data == exp_rd && !bus_rd && !bus_wr, "R6 rd_data held, R8 no restart",
            {rd_data, bus_rd, bus_wr}, {exp_rd, 2'b00});
        chk(!bus_atomic && !bus_nocache, "R9 sideband low", {bus_atomic, bus_nocache}, 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h0bad_5eed);
        repeat (3) @(negedge clk);
        chk(!bus_rd && !bus_wr && !busy && !done && !timed_out, "R1 reset controls",
            {bus_rd, bus_wr, busy, done, timed_out}, 0);
        chk(bus_addr == '0 && bus_wdata == '0 && rd_data == '0, "R1 reset data",
            {bus_addr, bus_wdata, rd_data}, 0);
        rst_n = 1'b1;
        // directed corners
        run_txn(1'b0, 23'h400001, 32'h0, 0, 32'hCAFE_0001, 1'b0);
        run_txn(1'b1, 23'h7FFFFF, 32'hDEAD_BEEF, 0, 32'h1111_1111, 1'b0);
        run_txn(1'b0, 23'h000010, 32'h0, LIMIT - 1, 32'hA5A5_5A5A, 1'b0);
        run_txn(1'b0, 23'h000020, 32'h0, LIMIT, 32'h0F0F_0F0F, 1'b0);
        run_txn(1'b1, 23'h000030, 32'h1234_5678, LIMIT + 10, 32'h0, 1'b1);
        run_txn(1'b0, 23'h2AAAAA, 32'h0, 3, 32'h7654_3210, 1'b1);
        // random mix
        for (int n = 0; n < 40; n++) begin
            int lat;
            lat = ($urandom_range(0, 9) == 0) ? 55 : int'($urandom_range(0, 11));
            run_txn(1'($urandom), ADDR_W'($urandom), $urandom, lat, $urandom, 1'($urandom));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule